// File: doc/BRIEF.md
# Serial Byte Master with Eight-Way Device Select

This block is a synchronous serial master that moves one 8-bit frame at a time to and from one of eight attached slave devices. A host presents a byte to send, a 3-bit device index and a baud divisor, then pulses a start input. The block generates the serial clock from the system clock and shifts the byte out most significant bit first. It samples the returning serial line into a receive byte and hands that byte back with a one-cycle completion pulse.

A single active-low frame strobe is low for the whole transfer. Eight active-low device selects are decoded from the index latched at start, and each select is gated by that strobe, so at most one device is selected at any time. The frame carries no framing bits. The strobe returns high half a serial-clock period after the last clock edge, which gives serial-to-parallel latches on the slave side a clean store edge.

Top module: `spi_dev_master`

## Requirements
- R1: Out of reset and whenever busy is low, `sck_o` is low, `strobe_n_o` is high, `done_o` is low and `mosi_o` is low.
- R2: While `strobe_n_o` is low, exactly one bit of `dev_sel_n_o` is low: bit number equal to the index latched at start (index 3'b101 drives bit 5 low). While `strobe_n_o` is high, all eight bits are high.
- R3: The latched byte appears on `mosi_o` most significant bit first. `mosi_o` changes during a frame only on a falling edge of `sck_o`, and it is stable at every rising edge.
- R4: `miso_i` is sampled on each of the 8 rising edges of `sck_o`. The first sample becomes bit 7 of `rx_byte_o`.
- R5: Each half period of `sck_o` lasts H system clocks, with H = divisor/2 rounded down. A start accepted at clock edge P0 raises `done_o` at edge P0 + 17*H, after 8 rising and 8 falling edges of `sck_o`.
- R6: A divisor of 0 or 1 is treated as 2 (H = 1). The divisor is captured when start is accepted.
- R7: Start is accepted only when busy is low. A start pulse during a frame is ignored and changes neither the frame data, the selected device nor the frame timing.
- R8: `done_o` is high for exactly one clock. In that cycle busy is low and `rx_byte_o` holds the received byte, which stays unchanged until the next completion.
- R9: `strobe_n_o` rises in the same cycle `done_o` rises, H clocks after the last falling edge of `sck_o`, while `sck_o` is low.
- R10: A start presented in the cycle where `done_o` is high is accepted, so frames can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a frame (accepted only when idle) |
| tx_byte_i | input | 8 | Byte to transmit, captured at start |
| dev_idx_i | input | 3 | Device index, captured at start |
| divisor_i | input | 8 | Baud divisor, captured at start |
| miso_i | input | 1 | Serial data from the slave |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rx_byte_o | output | 8 | Last received byte |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to the slave |
| strobe_n_o | output | 1 | Shared active-low frame strobe |
| dev_sel_n_o | output | 8 | Decoded active-low device selects |

## Verification
The end of one frame and the acceptance of the next can fall in the same cycle. The completion pulse, the strobe release and the clearing of busy all coincide with a start request. The bench provokes this by issuing the next start as soon as busy reads low, which is the done cycle. It judges the result by the done time of the second frame, which must be exactly 17*H + 1 cycles after its request, and by its data and select being correct. The second collision is a start pulse that arrives mid-frame. The scoreboard would see an extra or corrupted completion if that pulse leaked into the frame in progress.

// File: rtl/spi_dev_pkg.sv
package spi_dev_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/spi_baud_div.sv
module spi_baud_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] half_q, half_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  // Half period in system clocks; divisors below two collapse to one.
  always_comb begin
    half_d = (divisor_i < DIV_W'(2)) ? DIV_W'(1) : (divisor_i >> 1);
    tick_o = run_i && (cnt_q == half_q - DIV_W'(1));
    cnt_d  = (!run_i || tick_o) ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= DIV_W'(1);
      cnt_q  <= '0;
    end else begin
      if (load_i) half_q <= half_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_dev_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic [IDX_W-1:0]  dev_idx_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              load_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              strobe_n_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int LAST = 2 * DATA_W;
  localparam int EW   = $clog2(LAST + 1);

  seq_state_e        state_q, state_d;
  logic              sck_q, sck_d;
  logic              strobe_n_q, strobe_n_d;
  logic [EW-1:0]     edge_q, edge_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] out_q, out_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              done_q, done_d;
  logic              out_en;

  assign load_o = (state_q == SEQ_IDLE) && start_i;

  always_comb begin
    state_d    = state_q;
    sck_d      = sck_q;
    strobe_n_d = strobe_n_q;
    edge_d     = edge_q;
    tx_d       = tx_q;
    rx_d       = rx_q;
    out_d      = out_q;
    idx_d      = idx_q;
    done_d     = 1'b0;
    out_en     = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          state_d    = SEQ_RUN;
          tx_d       = tx_byte_i;
          idx_d      = dev_idx_i;
          edge_d     = '0;
          sck_d      = 1'b0;
          strobe_n_d = 1'b0;
        end
      end
      SEQ_RUN: begin
        if (tick_i) begin
          if (edge_q == EW'(LAST)) begin
            // Half period after the last falling edge: release the strobe.
            state_d    = SEQ_IDLE;
            strobe_n_d = 1'b1;
            done_d     = 1'b1;
            out_d      = rx_q;
            out_en     = 1'b1;
          end else begin
            edge_d = edge_q + EW'(1);
            if (!sck_q) begin
              sck_d = 1'b1;
              rx_d  = {rx_q[DATA_W-2:0], miso_i};
            end else begin
              sck_d = 1'b0;
              tx_d  = {tx_q[DATA_W-2:0], 1'b0};
            end
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      sck_q      <= 1'b0;
      strobe_n_q <= 1'b1;
      edge_q     <= '0;
      tx_q       <= '0;
      rx_q       <= '0;
      out_q      <= '0;
      idx_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      sck_q      <= sck_d;
      strobe_n_q <= strobe_n_d;
      edge_q     <= edge_d;
      tx_q       <= tx_d;
      rx_q       <= rx_d;
      idx_q      <= idx_d;
      done_q     <= done_d;
      if (out_en) out_q <= out_d;
    end
  end

  assign busy_o     = (state_q == SEQ_RUN);
  assign sck_o      = sck_q;
  assign mosi_o     = tx_q[DATA_W-1];
  assign strobe_n_o = strobe_n_q;
  assign idx_o      = idx_q;
  assign done_o     = done_q;
  assign rx_byte_o  = out_q;
endmodule

// File: rtl/spi_sel_decode.sv
module spi_sel_decode #(
  parameter int IDX_W = 3,
  localparam int NDEV = 1 << IDX_W
) (
  input  logic             strobe_n_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [NDEV-1:0]  sel_n_o
);
  for (genvar g = 0; g < NDEV; g++) begin : g_sel
    assign sel_n_o[g] = strobe_n_i | (idx_i != IDX_W'(g));
  end
endmodule

// File: rtl/spi_dev_master.sv
module spi_dev_master #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3,
  parameter int DIV_W  = 8,
  localparam int NDEV  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic [IDX_W-1:0]  dev_idx_i,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              strobe_n_o,
  output logic [NDEV-1:0]   dev_sel_n_o
);
  logic             load;
  logic             tick;
  logic [IDX_W-1:0] idx;

  spi_baud_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .divisor_i (divisor_i),
    .run_i     (busy_o),
    .tick_o    (tick)
  );

  spi_frame_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tx_byte_i  (tx_byte_i),
    .dev_idx_i  (dev_idx_i),
    .tick_i     (tick),
    .miso_i     (miso_i),
    .load_o     (load),
    .busy_o     (busy_o),
    .sck_o      (sck_o),
    .mosi_o     (mosi_o),
    .strobe_n_o (strobe_n_o),
    .idx_o      (idx),
    .done_o     (done_o),
    .rx_byte_o  (rx_byte_o)
  );

  spi_sel_decode #(.IDX_W(IDX_W)) u_dec (
    .strobe_n_i (strobe_n_o),
    .idx_i      (idx),
    .sel_n_o    (dev_sel_n_o)
  );
endmodule

// File: rtl/spi_dev_master_chk.sv
module spi_dev_master_chk #(
  parameter int NDEV = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy_o,
  input logic            done_o,
  input logic            sck_o,
  input logic            mosi_o,
  input logic            strobe_n_o,
  input logic [NDEV-1:0] dev_sel_n_o
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sck_o && strobe_n_o));

  a_r2_one_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n_o |-> ($countones(~dev_sel_n_o) == 1));

  a_r2_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_n_o |-> (&dev_sel_n_o));

  a_r3_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$stable(mosi_o)) |-> $fell(sck_o));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r9_strobe_after: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n_o) |-> (done_o && !sck_o && $past(!sck_o)));
endmodule

bind spi_dev_master spi_dev_master_chk #(.NDEV(NDEV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .sck_o       (sck_o),
  .mosi_o      (mosi_o),
  .strobe_n_o  (strobe_n_o),
  .dev_sel_n_o (dev_sel_n_o)
);

// File: tb/spi_dev_master_bench.sv
module spi_dev_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] tx_byte_i = '0;
  logic [2:0] dev_idx_i = '0;
  logic [7:0] divisor_i = '0;
  logic       miso_i;
  logic       busy_o, done_o, sck_o, mosi_o, strobe_n_o;
  logic [7:0] rx_byte_o, dev_sel_n_o;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_dev_master u_spi_dev_master (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_byte_i(tx_byte_i),
    .dev_idx_i(dev_idx_i), .divisor_i(divisor_i), .miso_i(miso_i),
    .busy_o(busy_o), .done_o(done_o), .rx_byte_o(rx_byte_o), .sck_o(sck_o),
    .mosi_o(mosi_o), .strobe_n_o(strobe_n_o), .dev_sel_n_o(dev_sel_n_o)
  );

  typedef struct {
    logic [7:0] tx;
    logic [7:0] sl;
    logic [2:0] idx;
    int         half;
    int         t0;
  } item_t;
  item_t sb[$];

  // Slave model: shift register loaded when the strobe falls.
  logic [7:0] slave_tx = '0;
  logic [7:0] sl_sh = '0;
  logic [7:0] cap = '0;
  assign miso_i = sl_sh[7];
  always @(negedge strobe_n_o) sl_sh = slave_tx;
  always @(negedge sck_o) if (!strobe_n_o) sl_sh = {sl_sh[6:0], 1'b0};
  always @(posedge sck_o) cap = {cap[6:0], mosi_o};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: waits for idle (the done cycle when a frame is running), then starts.
  task automatic run_frame(input logic [7:0] tx, input logic [7:0] sl,
                           input logic [2:0] idx, input logic [7:0] div);
    item_t it;
    while (busy_o) @(negedge clk);
    it.tx = tx; it.sl = sl; it.idx = idx;
    it.half = (div < 8'd2) ? 1 : int'(div >> 1);
    it.t0 = cyc;
    sb.push_back(it);
    slave_tx  = sl;
    tx_byte_i = tx; dev_idx_i = idx; divisor_i = div;
    start_i   = 1'b1;
    @(negedge clk);
    start_i   = 1'b0;
  endtask

  // Monitor: pops expectations on every completion.
  logic [7:0] sel_seen = '0;
  always @(negedge clk) begin
    if (rst_n && !strobe_n_o) sel_seen = sel_seen | ~dev_sel_n_o;
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R7 unexpected completion", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(rx_byte_o == it.sl, "R4 received byte", rx_byte_o, it.sl);
        chk(cap == it.tx, "R3 transmitted byte", cap, it.tx);
        chk(sel_seen == (8'd1 << it.idx), "R2 decoded select", sel_seen, 8'd1 << it.idx);
        chk(cyc - it.t0 == 17 * it.half + 1, "R5 R6 R10 frame length",
            cyc - it.t0, 17 * it.half + 1);
        chk(!busy_o && strobe_n_o && !sck_o, "R8 R9 done state",
            {busy_o, strobe_n_o, sck_o}, 3'b010);
      end
      sel_seen = '0;
    end
  end

  // Single-cycle done check: sampled one cycle after each completion.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      logic [7:0] held;
      held = rx_byte_o;
      @(negedge clk);
      chk(!done_o, "R8 done width", done_o, 0);
      chk(rx_byte_o == held, "R8 byte held", rx_byte_o, held);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !sck_o && strobe_n_o && !done_o && !mosi_o && (&dev_sel_n_o),
        "R1 reset state", {busy_o, sck_o, strobe_n_o, done_o, mosi_o}, 5'b00100);
    rst_n = 1'b1;
    @(negedge clk);

    run_frame(8'hA5, 8'h3C, 3'd5, 8'd4);
    run_frame(8'h01, 8'h80, 3'd0, 8'd0);   // R6 divisor 0
    run_frame(8'hFF, 8'h00, 3'd7, 8'd1);   // R6 divisor 1
    run_frame(8'h00, 8'hFF, 3'd2, 8'd6);   // R10 back to back
    run_frame(8'h5A, 8'hC3, 3'd3, 8'd10);
    repeat (10) @(negedge clk);
    // R7: start pulse while busy must be ignored.
    chk(busy_o, "R7 busy before poke", busy_o, 1);
    tx_byte_i = 8'hEE; dev_idx_i = 3'd6; divisor_i = 8'd2;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R7 busy after poke", busy_o, 1);
    run_frame(8'h81, 8'h7E, 3'd4, 8'd7);   // odd divisor
    run_frame(8'h96, 8'h69, 3'd1, 8'd255);
    while (busy_o || sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy_o && !sck_o && strobe_n_o && !mosi_o && (&dev_sel_n_o),
        "R1 idle after frames", {busy_o, sck_o, strobe_n_o, mosi_o}, 4'b0010);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule